// File: doc/BRIEF.md
# Pipelined Synchronous Byte-Write SRAM

This block is a synthesizable behavioural model of a single-port synchronous static RAM with a four-byte word. Every input (address, write data, chip selects and write qualifiers) is captured on the rising clock edge. The registered command then acts on a storage array that is split into one lane per byte. A read loads an output register one edge after its address was captured. A write updates only the lanes its qualifiers select.

Three chip-select inputs must all be active at once to select the device. An all-bytes write strobe overrides the per-byte controls. The read path is two registers deep: a command register, then an output-state register. Because of this, a deselect reaches the data-drive flag only after both stages. The bidirectional bus is modelled as a write-data input, a read-data output and a drive flag.

The output-state machine has three states. `OS_OFF` means the bus is not driven. `OS_READ` means the bus shows the data of a registered read. `OS_WRITE` means a write is in progress and the bus is not driven. On every edge the next state follows the registered command: a deselect goes to `OS_OFF`, a read goes to `OS_READ` and a write goes to `OS_WRITE`, from any state. Reset forces `OS_OFF`.

Top module: `pipe_sram`

## Requirements
- R1: While reset (`rst_n` low, sampled on the clock) is applied and right after it, `rd_drive` is 0 and `rd_data` is 0.
- R2: A read captured on clock edge k loads `rd_data` with the stored word on edge k+1, and `rd_drive` is 1 from then until edge k+2 (when `out_en_n` is 0).
- R3: With `all_wr_n` low on a selected cycle, all four bytes are written, whatever `byte_wr_en_n` and `lane_wr_n` say.
- R4: With `all_wr_n` high and `byte_wr_en_n` low, byte k (bits 8k+7..8k) is written only when `lane_wr_n[k]` is 0. The other bytes keep their values, so a write covers one to four bytes.
- R5: A selected cycle with no write qualifier is a read. That is, `all_wr_n` is high and either `byte_wr_en_n` is high or all `lane_wr_n` bits are 1. While `byte_wr_en_n` is high, `lane_wr_n` has no effect.
- R6: The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect, which writes nothing.
- R7: A deselect captured on edge k drives `rd_drive` low after edge k+1. A read captured on edge k-1 still drives the bus between edges k and k+1.
- R8: `out_en_n` high forces `rd_drive` low at once, without a clock, and leaves `rd_data` unchanged.
- R9: In the cycle after a write is captured, `rd_drive` is 0.
- R10: `rd_data` keeps the last read word through every cycle that is not a read result.
- R11: A read captured on the edge right after a write to the same address returns the newly written bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW (8) | Word address |
| wr_data | input | 32 | Write data, byte k in bits 8k+7..8k |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Write all bytes, active low |
| byte_wr_en_n | input | 1 | Enable per-byte writes, active low |
| lane_wr_n | input | 4 | Per-byte write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rd_data | output | 32 | Registered read data |
| rd_drive | output | 1 | High when the bus would be driven |

## Verification
The hardest behaviour to provoke is the overlap in the two-stage drive pipeline. A read result must still be on the bus while the next cycle's deselect or write is already captured. A blocked write must also be shown to have left memory untouched. To reach this, the stimulus table places deselects that carry an active all-bytes strobe and conflicting data directly after reads, then reads the same word back. Each sample is taken one edge after the command it judges, with `out_en_n` toggled in that very cycle. Directed sequences add back-to-back write-then-read to one address, partial writes at the top address, and a reset in the middle of a run.

// File: rtl/sram_pkg.sv
package sram_pkg;
    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    typedef enum logic [1:0] {
        OS_OFF   = 2'd0,
        OS_READ  = 2'd1,
        OS_WRITE = 2'd2
    } ostate_e;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
    import sram_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              all_wr_n,
    input  logic              byte_wr_en_n,
    input  logic [NBYTES-1:0] lane_wr_n,
    output cmd_e              cmd,
    output logic [NBYTES-1:0] lane_en
);
    logic selected;
    logic [NBYTES-1:0] lane_req;

    assign selected = !sel_a_n && sel_b && !sel_c_n;

    // Global strobe overrides the per-byte path.
    always_comb begin
        if (!all_wr_n) begin
            lane_req = {NBYTES{1'b1}};
        end else if (!byte_wr_en_n) begin
            lane_req = ~lane_wr_n;
        end else begin
            lane_req = '0;
        end
    end

    always_comb begin
        if (!selected) begin
            cmd     = CMD_DESEL;
            lane_en = '0;
        end else if (|lane_req) begin
            cmd     = CMD_WRITE;
            lane_en = lane_req;
        end else begin
            cmd     = CMD_READ;
            lane_en = '0;
        end
    end
endmodule

// File: rtl/sram_in_reg.sv
module sram_in_reg
    import sram_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int AW     = 8,
    localparam int DW    = NBYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd_d,
    input  logic [NBYTES-1:0] lane_en_d,
    input  logic [AW-1:0]     addr_d,
    input  logic [DW-1:0]     wdata_d,
    output cmd_e              cmd_q,
    output logic [NBYTES-1:0] lane_en_q,
    output logic [AW-1:0]     addr_q,
    output logic [DW-1:0]     wdata_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= CMD_DESEL;
            lane_en_q <= '0;
        end else begin
            cmd_q     <= cmd_d;
            lane_en_q <= lane_en_d;
        end
    end

    always_ff @(posedge clk) begin
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
    end

    // R4: a registered write always covers at least one byte
    p_write_has_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_WRITE) |-> (lane_en_q != '0));

    // R6: lanes are never armed outside a write
    p_no_lane_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != CMD_WRITE) |-> (lane_en_q == '0));
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import sram_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = NBYTES * 8
) (
    input  logic              clk,
    input  cmd_e              cmd_q,
    input  logic [NBYTES-1:0] lane_en_q,
    input  logic [AW-1:0]     addr_q,
    input  logic [DW-1:0]     wdata_q,
    output logic [DW-1:0]     rd_word
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [7:0] store [DEPTH];
        logic       wr_here;

        assign wr_here = (cmd_q == CMD_WRITE) && lane_en_q[g];

        always_ff @(posedge clk) begin
            if (wr_here) begin
                store[addr_q] <= wdata_q[g*8 +: 8];
            end
        end

        assign rd_word[g*8 +: 8] = store[addr_q];
    end
endmodule

// File: rtl/sram_out_pipe.sv
module sram_out_pipe
    import sram_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_e          cmd_q,
    input  logic [DW-1:0] rd_word,
    input  logic          out_en_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_drive
);
    ostate_e state, state_nx;

    always_comb begin
        unique case (cmd_q)
            CMD_READ:  state_nx = OS_READ;
            CMD_WRITE: state_nx = OS_WRITE;
            CMD_DESEL: state_nx = OS_OFF;
            default:   state_nx = OS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OS_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (cmd_q == CMD_READ) begin
            rd_data <= rd_word;
        end
    end

    assign rd_drive = !out_en_n && (state == OS_READ);

    // R7: a registered deselect turns the bus off on the following edge
    p_desel_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_DESEL) |=> (state == OS_OFF));

    // R9: no drive in the cycle after a write
    p_write_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_WRITE) |=> !rd_drive);

    // R10: read data only changes on a read result
    p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != CMD_READ) |=> $stable(rd_data));

    // R2: a registered read leads to the read state
    p_read_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_READ) |=> (state == OS_READ));
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
    import sram_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = NBYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              all_wr_n,
    input  logic              byte_wr_en_n,
    input  logic [NBYTES-1:0] lane_wr_n,
    input  logic              out_en_n,
    output logic [DW-1:0]     rd_data,
    output logic              rd_drive
);
    cmd_e              cmd_d, cmd_q;
    logic [NBYTES-1:0] lane_en_d, lane_en_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     rd_word;

    sram_cmd_decode #(.NBYTES(NBYTES)) u_dec (
        .sel_a_n      (sel_a_n),
        .sel_b        (sel_b),
        .sel_c_n      (sel_c_n),
        .all_wr_n     (all_wr_n),
        .byte_wr_en_n (byte_wr_en_n),
        .lane_wr_n    (lane_wr_n),
        .cmd          (cmd_d),
        .lane_en      (lane_en_d)
    );

    sram_in_reg #(.NBYTES(NBYTES), .AW(AW)) u_inreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_d     (cmd_d),
        .lane_en_d (lane_en_d),
        .addr_d    (addr),
        .wdata_d   (wr_data),
        .cmd_q     (cmd_q),
        .lane_en_q (lane_en_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q)
    );

    sram_lane_array #(.NBYTES(NBYTES), .DEPTH(DEPTH)) u_array (
        .clk       (clk),
        .cmd_q     (cmd_q),
        .lane_en_q (lane_en_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rd_word   (rd_word)
    );

    sram_out_pipe #(.DW(DW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_q    (cmd_q),
        .rd_word  (rd_word),
        .out_en_n (out_en_n),
        .rd_data  (rd_data),
        .rd_drive (rd_drive)
    );

    // R3: global strobe on a selected cycle arms every lane
    p_all_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_a_n && sel_b && !sel_c_n && !all_wr_n)
        |=> (cmd_q == CMD_WRITE && lane_en_q == {NBYTES{1'b1}}));

    // R6: any inactive select yields a deselect
    p_desel_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a_n || !sel_b || sel_c_n) |=> (cmd_q == CMD_DESEL));

    // R5: selected, no qualifier -> read
    p_plain_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_a_n && sel_b && !sel_c_n && all_wr_n
         && (byte_wr_en_n || lane_wr_n == {NBYTES{1'b1}}))
        |=> (cmd_q == CMD_READ));

    // R8: output enable gates drive without a clock
    always_comb begin
        if (rst_n && out_en_n) begin
            a_oe_gate_r8: assert (!rd_drive);
        end
    end
endmodule

// File: tb/test_pipe_sram.sv
module test_pipe_sram;
    localparam int NB    = 4;
    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          all_wr_n = 1'b1;
    logic          byte_wr_en_n = 1'b1;
    logic [NB-1:0] lane_wr_n = '1;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_drive;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] model [DEPTH];
    logic          pend_rd = 1'b0;
    logic [DW-1:0] last_rd = '0;
    logic          exp_drv;
    logic [DW-1:0] exp_dat;

    always #10 clk = ~clk;

    pipe_sram #(.NBYTES(NB), .DEPTH(DEPTH)) i_pipe_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .all_wr_n(all_wr_n), .byte_wr_en_n(byte_wr_en_n),
        .lane_wr_n(lane_wr_n), .out_en_n(out_en_n),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    typedef struct packed {
        logic          a_n;
        logic          b;
        logic          c_n;
        logic          gw_n;
        logic          bwe_n;
        logic [3:0]    lw_n;
        logic          oe_n;
        logic [7:0]    ad;
        logic [31:0]   wd;
        logic          e_drv;
        logic [31:0]   e_dat;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,1'b0, 1'b0,1'b1,4'hF,1'b0, 8'd3, 32'h11223344, 1'b0, 32'h0},
        '{1'b0,1'b1,1'b0, 1'b1,1'b0,4'hA,1'b0, 8'd3, 32'hAABBCCDD, 1'b0, 32'h0},
        '{1'b0,1'b1,1'b0, 1'b1,1'b1,4'hF,1'b0, 8'd3, 32'h0,        1'b0, 32'h0},
        '{1'b0,1'b1,1'b0, 1'b1,1'b1,4'h0,1'b0, 8'd3, 32'h0,        1'b1, 32'h11BB33DD},
        '{1'b0,1'b0,1'b0, 1'b0,1'b1,4'hF,1'b0, 8'd3, 32'hFFFFFFFF, 1'b1, 32'h11BB33DD},
        '{1'b0,1'b1,1'b0, 1'b1,1'b0,4'hF,1'b0, 8'd3, 32'h0,        1'b0, 32'h11BB33DD},
        '{1'b1,1'b1,1'b0, 1'b1,1'b1,4'hF,1'b0, 8'd3, 32'h0,        1'b1, 32'h11BB33DD},
        '{1'b0,1'b1,1'b0, 1'b1,1'b1,4'hF,1'b0, 8'd3, 32'h0,        1'b0, 32'h11BB33DD},
        '{1'b0,1'b1,1'b0, 1'b1,1'b1,4'hF,1'b1, 8'd3, 32'h0,        1'b0, 32'h11BB33DD},
        '{1'b0,1'b1,1'b1, 1'b1,1'b1,4'hF,1'b0, 8'd3, 32'h0,        1'b1, 32'h11BB33DD}
    };

    task automatic check(input string req, input logic e_drv, input logic [DW-1:0] e_dat);
        checks++;
        if (rd_drive !== e_drv || rd_data !== e_dat) begin
            fails++;
            $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
                     req, rd_drive, rd_data, e_drv, e_dat);
        end
    endtask

    // Drives one command; afterwards the outputs show the previous command.
    task automatic step(input logic a_n, input logic b, input logic c_n,
                        input logic gw_n, input logic bwe_n, input logic [3:0] lw_n,
                        input logic oe_n, input logic [7:0] ad, input logic [31:0] wd);
        logic sel, wr;
        logic [3:0] lanes;
        @(negedge clk);
        sel_a_n = a_n; sel_b = b; sel_c_n = c_n; all_wr_n = gw_n;
        byte_wr_en_n = bwe_n; lane_wr_n = lw_n; out_en_n = oe_n;
        addr = ad; wr_data = wd;
        exp_drv = pend_rd & !oe_n;
        exp_dat = last_rd;
        sel = !a_n && b && !c_n;
        lanes = !gw_n ? 4'hF : (!bwe_n ? ~lw_n : 4'h0);
        wr = (lanes != 4'h0);
        if (sel && wr) begin
            for (int k = 0; k < NB; k++)
                if (lanes[k]) model[ad][k*8 +: 8] = wd[k*8 +: 8];
            pend_rd = 1'b0;
        end else if (sel) begin
            pend_rd = 1'b1;
            last_rd = model[ad];
        end else begin
            pend_rd = 1'b0;
        end
        @(posedge clk);
        #5;
    endtask

    task automatic wr_all(input logic [7:0] ad, input logic [31:0] wd, input string req);
        step(1'b0,1'b1,1'b0, 1'b0,1'b1,4'hF,1'b0, ad, wd);
        check(req, exp_drv, exp_dat);
    endtask

    task automatic wr_lanes(input logic [7:0] ad, input logic [3:0] lw, input logic [31:0] wd, input string req);
        step(1'b0,1'b1,1'b0, 1'b1,1'b0,lw,1'b0, ad, wd);
        check(req, exp_drv, exp_dat);
    endtask

    task automatic rd(input logic [7:0] ad, input string req);
        step(1'b0,1'b1,1'b0, 1'b1,1'b1,4'hF,1'b0, ad, 32'h0);
        check(req, exp_drv, exp_dat);
    endtask

    task automatic idle(input string req);
        step(1'b1,1'b0,1'b1, 1'b1,1'b1,4'hF,1'b0, 8'd0, 32'h0);
        check(req, exp_drv, exp_dat);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #5;
        check("R1 during reset", 1'b0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        check("R1 after reset", 1'b0, 32'h0);

        // Vector table: R3 R4 R5 R6 R7 R8 R2 R10
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].a_n, TBL[i].b, TBL[i].c_n, TBL[i].gw_n, TBL[i].bwe_n,
                 TBL[i].lw_n, TBL[i].oe_n, TBL[i].ad, TBL[i].wd);
            check($sformatf("R2/R3/R4/R5/R6/R7/R8 vector %0d", i), TBL[i].e_drv, TBL[i].e_dat);
        end
        idle("R7 deselect after final vector");

        // R11: write then read on the next edge, same address
        wr_all(8'h10, 32'hCAFEF00D, "R9 write quiet");
        rd(8'h10, "R9 write quiet before read");
        idle("R11 read after write");

        // R4 boundary at top address
        wr_all(8'(DEPTH-1), 32'h01020304, "R3 top full write");
        wr_lanes(8'(DEPTH-1), 4'b0111, 32'hEE000000, "R4 top lane3 write");
        rd(8'(DEPTH-1), "R10 hold during writes");
        idle("R4 top address partial write");

        // R4: every lane mask over a range of addresses
        for (int a = 0; a < 16; a++)
            wr_all(8'(32 + a), 32'h5A5A5A5A ^ (a * 32'h01010101), "R3 sweep fill");
        for (int a = 0; a < 16; a++)
            wr_lanes(8'(32 + a), 4'(a), 32'hF0E1D2C3 + a, "R4/R5 sweep mask");
        for (int a = 0; a < 16; a++)
            rd(8'(32 + a), "R2/R4 sweep readback");
        idle("R2/R4 sweep last");

        // R8: output enable toggled while a read result is held
        rd(8'h10, "R2 prep");
        step(1'b0,1'b1,1'b0, 1'b1,1'b1,4'hF,1'b1, 8'h10, 32'h0);
        check("R8 oe high during read result", exp_drv, exp_dat);
        step(1'b0,1'b1,1'b0, 1'b1,1'b1,4'hF,1'b0, 8'h10, 32'h0);
        check("R8 oe low again", exp_drv, exp_dat);
        idle("R7 deselect after reads");

        // R1: reset in mid-run
        rd(8'h10, "R2 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
        repeat (2) @(posedge clk);
        #5;
        check("R1 mid-run reset", 1'b0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        pend_rd = 1'b0;
        last_rd = '0;
        rd(8'h10, "R1 first cycle after reset");
        idle("R2 memory kept across reset");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule